// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This block supervises a five-stage in-order integer pipeline whose stages are fetch, decode with register read, execute, memory and writeback. Every cycle it compares the register fields of the instruction waiting in decode against the fields of the three older instructions still in flight (execute, memory, writeback). From that comparison it produces four kinds of output. The first is a stall that freezes fetch and decode. The second is a bubble request that clears the control of whatever enters execute. The third is a forwarding select for each operand of the instruction currently in execute. The fourth is a one-hot flag that names the dependence kind found.

All instructions write the register file in stage 5 through its single write port. Because of this, an ALU result reaching execute through forwarding needs no stall. Only a load directly followed by a consumer of its result costs a cycle. Branches are resolved by stalling: once a branch leaves decode, the unit holds the front end for a fixed penalty of two cycles. Register number 0 is hard-wired to zero. A field value of 0 therefore also means "no register", so a descriptor needs no separate enable bits. A bubble in a stage is presented as all-zero register fields.

Top module: `pipe_hazard_unit`

## Requirements
- R1: With `id_valid` high, if a nonzero `id_rs1` or `id_rs2` equals the `rd` field of the execute, memory or writeback stage, `hz_kind` is 3'b001 (read-after-write) in the same cycle.
- R2: With no read-after-write, if a nonzero `id_rd` equals the `rd` field of an older stage, `hz_kind` is 3'b010 (write-after-write).
- R3: With neither of the above, if a nonzero `id_rd` equals an `rs1` or `rs2` field of an older stage, `hz_kind` is 3'b100 (write-after-read). Otherwise, or when `id_valid` is low, `hz_kind` is 3'b000. At most one bit of `hz_kind` is ever set.
- R4: Register 0 never takes part in a match. Fields equal to 0 produce no dependence flag, no forwarding and no load-use stall.
- R5: `fwd_a` (for `ex_rs1`) and `fwd_b` (for `ex_rs2`) read 2'b01 when the operand is nonzero and equals `mem_rd`. They read 2'b10 when it is nonzero and equals `wb_rd` only. Otherwise they read 2'b00, which selects the register file. This is combinational.
- R6: When an operand matches both `mem_rd` and `wb_rd`, the memory-stage value (2'b01) is selected.
- R7: With `id_valid` high, `ex_load` high and a nonzero `ex_rd` equal to `id_rs1` or `id_rs2`, `load_use`, `stall` and `ex_bubble` are all high in that cycle. A matching producer in execute that is not a load causes no stall.
- R8: A branch issues at a clock edge where `id_valid` and `id_branch` are high and `stall` is low. In that case `stall` and `ex_bubble` are high for exactly the next two cycles, barring a load-use stall.
- R9: A branch held in decode by a stall does not issue, and it starts no penalty until the edge at which it actually leaves decode.
- R10: After synchronous reset, with all inputs at zero, `stall`, `ex_bubble`, `load_use`, `hz_kind`, `fwd_a` and `fwd_b` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_rs1 | input | REG_W | Decode first source register (0 = none) |
| id_rs2 | input | REG_W | Decode second source register (0 = none) |
| id_rd | input | REG_W | Decode destination register (0 = none) |
| id_branch | input | 1 | Decode instruction is a branch |
| ex_rs1 | input | REG_W | Execute first source register |
| ex_rs2 | input | REG_W | Execute second source register |
| ex_rd | input | REG_W | Execute destination register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rs1 | input | REG_W | Memory-stage first source register |
| mem_rs2 | input | REG_W | Memory-stage second source register |
| mem_rd | input | REG_W | Memory-stage destination register |
| wb_rs1 | input | REG_W | Writeback first source register |
| wb_rs2 | input | REG_W | Writeback second source register |
| wb_rd | input | REG_W | Writeback destination register |
| stall | output | 1 | Hold fetch and decode registers |
| ex_bubble | output | 1 | Clear control of the instruction entering execute |
| fwd_a | output | 2 | Forward select for execute operand 1 |
| fwd_b | output | 2 | Forward select for execute operand 2 |
| hz_kind | output | 3 | One-hot dependence kind: bit0 RAW, bit1 WAW, bit2 WAR |
| load_use | output | 1 | Load-use stall condition present |

## Verification
The bench aims at an operand that matches both the memory and the writeback destination. A design with the wrong priority would forward the older writeback value. It also drives instructions whose fields are all zero next to older stages that also carry zeros. A design that treated register 0 as real would raise false dependences and forwards. Load-use is exercised next to an ALU producer in the same slot. This catches a unit that stalls on every read-after-write, or one that never stalls. Finally, a branch is held in decode by a load-use stall and then released. A counter that started on the held cycle, or that ran for one or three cycles, shows up as a stall in the wrong cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Forwarding source for one execute operand
    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_MEM = 2'd1,
        FWD_WB  = 2'd2
    } fwd_sel_e;

    // Bit positions of the hazard-kind flag
    localparam int KIND_RAW = 0;
    localparam int KIND_WAW = 1;
    localparam int KIND_WAR = 2;
    localparam int KIND_W   = 3;

    // Raw (unprioritised) dependence findings
    typedef struct packed {
        logic raw;
        logic waw;
        logic war;
    } dep_t;

endpackage

// File: rtl/hz_src_fwd.sv
module hz_src_fwd
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] mem_rd,
    input  logic [REG_W-1:0] wb_rd,
    output fwd_sel_e         sel
);

    logic src_live;
    assign src_live = (src != '0);

    always_comb begin
        if (src_live && (src == mem_rd))
            sel = FWD_MEM;
        else if (src_live && (src == wb_rd))
            sel = FWD_WB;
        else
            sel = FWD_RF;
    end

    // R6
    wb_not_over_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == FWD_WB) |-> (src != mem_rd));

    // R4
    zero_src_rf_chk: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |-> (sel == FWD_RF));

endmodule

// File: rtl/hz_dep_check.sv
module hz_dep_check
    import hz_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int N_OLD = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             id_valid,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic [REG_W-1:0] id_rd,
    input  logic [REG_W-1:0] old_rd  [N_OLD],
    input  logic [REG_W-1:0] old_rs1 [N_OLD],
    input  logic [REG_W-1:0] old_rs2 [N_OLD],
    output dep_t             deps
);

    function automatic logic same_nz(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
        return (a != '0) && (a == b);
    endfunction

    logic [N_OLD-1:0] raw_hit;
    logic [N_OLD-1:0] waw_hit;
    logic [N_OLD-1:0] war_hit;

    for (genvar g = 0; g < N_OLD; g++) begin : g_stage
        assign raw_hit[g] = same_nz(id_rs1, old_rd[g]) | same_nz(id_rs2, old_rd[g]);
        assign waw_hit[g] = same_nz(id_rd, old_rd[g]);
        assign war_hit[g] = same_nz(id_rd, old_rs1[g]) | same_nz(id_rd, old_rs2[g]);
    end

    assign deps.raw = id_valid & (|raw_hit);
    assign deps.waw = id_valid & (|waw_hit);
    assign deps.war = id_valid & (|war_hit);

    // R4
    zero_dst_chk: assert property (@(posedge clk) disable iff (rst)
        (id_rd == '0) |-> (!deps.waw && !deps.war));

    // R3
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> (deps == '0));

endmodule

// File: rtl/hz_branch_ctr.sv
module hz_branch_ctr #(
    parameter int PENALTY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic issue,
    output logic busy
);

    localparam int CNT_W = $clog2(PENALTY + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PENALTY);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (issue)
            cnt <= LOAD_VAL;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R8
    br_penalty_chk: assert property (@(posedge clk) disable iff (rst)
        issue |=> busy);

    // R8
    br_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LOAD_VAL);

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
    import hz_pkg::*;
#(
    parameter int REG_W      = 5,
    parameter int BR_PENALTY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              id_valid,
    input  logic [REG_W-1:0]  id_rs1,
    input  logic [REG_W-1:0]  id_rs2,
    input  logic [REG_W-1:0]  id_rd,
    input  logic              id_branch,
    input  logic [REG_W-1:0]  ex_rs1,
    input  logic [REG_W-1:0]  ex_rs2,
    input  logic [REG_W-1:0]  ex_rd,
    input  logic              ex_load,
    input  logic [REG_W-1:0]  mem_rs1,
    input  logic [REG_W-1:0]  mem_rs2,
    input  logic [REG_W-1:0]  mem_rd,
    input  logic [REG_W-1:0]  wb_rs1,
    input  logic [REG_W-1:0]  wb_rs2,
    input  logic [REG_W-1:0]  wb_rd,
    output logic              stall,
    output logic              ex_bubble,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic [KIND_W-1:0] hz_kind,
    output logic              load_use
);

    localparam int N_OLD = 3;
    localparam int N_OPS = 2;

    // ---------------- dependence classification ----------------
    logic [REG_W-1:0] old_rd  [N_OLD];
    logic [REG_W-1:0] old_rs1 [N_OLD];
    logic [REG_W-1:0] old_rs2 [N_OLD];
    dep_t             deps;

    assign old_rd[0]  = ex_rd;
    assign old_rd[1]  = mem_rd;
    assign old_rd[2]  = wb_rd;
    assign old_rs1[0] = ex_rs1;
    assign old_rs1[1] = mem_rs1;
    assign old_rs1[2] = wb_rs1;
    assign old_rs2[0] = ex_rs2;
    assign old_rs2[1] = mem_rs2;
    assign old_rs2[2] = wb_rs2;

    hz_dep_check #(.REG_W(REG_W), .N_OLD(N_OLD)) u_dep (
        .clk      (clk),
        .rst      (rst),
        .id_valid (id_valid),
        .id_rs1   (id_rs1),
        .id_rs2   (id_rs2),
        .id_rd    (id_rd),
        .old_rd   (old_rd),
        .old_rs1  (old_rs1),
        .old_rs2  (old_rs2),
        .deps     (deps)
    );

    // Priority RAW > WAW > WAR, presented one-hot
    always_comb begin
        hz_kind = '0;
        if (deps.raw)
            hz_kind[KIND_RAW] = 1'b1;
        else if (deps.waw)
            hz_kind[KIND_WAW] = 1'b1;
        else if (deps.war)
            hz_kind[KIND_WAR] = 1'b1;
    end

    // ---------------- forwarding for the execute operands ----------------
    logic [REG_W-1:0] ex_src [N_OPS];
    fwd_sel_e         op_sel [N_OPS];

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar k = 0; k < N_OPS; k++) begin : g_op
        hz_src_fwd #(.REG_W(REG_W)) u_fwd (
            .clk    (clk),
            .rst    (rst),
            .src    (ex_src[k]),
            .mem_rd (mem_rd),
            .wb_rd  (wb_rd),
            .sel    (op_sel[k])
        );
    end

    assign fwd_a = op_sel[0];
    assign fwd_b = op_sel[1];

    // ---------------- load-use and branch stalls ----------------
    logic ld_dst_live;
    logic br_busy;
    logic br_issue;

    assign ld_dst_live = ex_load && (ex_rd != '0);
    assign load_use    = id_valid && ld_dst_live &&
                         ((id_rs1 == ex_rd) || (id_rs2 == ex_rd));

    assign stall     = load_use | br_busy;
    assign ex_bubble = stall;
    assign br_issue  = id_valid & id_branch & ~stall;

    hz_branch_ctr #(.PENALTY(BR_PENALTY)) u_br (
        .clk   (clk),
        .rst   (rst),
        .issue (br_issue),
        .busy  (br_busy)
    );

    // R3
    kind_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hz_kind));

    // R7
    load_use_stall_chk: assert property (@(posedge clk) disable iff (rst)
        load_use |-> (stall && ex_bubble));

    // R1
    raw_ex_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (id_valid && ex_rd != '0 && id_rs1 == ex_rd) |-> hz_kind[KIND_RAW]);

    // R9
    held_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (id_valid && id_branch && load_use && !br_busy) |=> !br_busy);

endmodule

// File: tb/pipe_hazard_unit_bench.sv
module pipe_hazard_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int RW         = 5;
    localparam int PEN        = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          id_valid, id_branch, ex_load;
    logic [RW-1:0] id_rs1, id_rs2, id_rd;
    logic [RW-1:0] ex_rs1, ex_rs2, ex_rd;
    logic [RW-1:0] mem_rs1, mem_rs2, mem_rd;
    logic [RW-1:0] wb_rs1, wb_rs2, wb_rd;
    logic          stall, ex_bubble, load_use;
    logic [1:0]    fwd_a, fwd_b;
    logic [2:0]    hz_kind;

    int n_chk     = 0;
    int n_fail    = 0;
    int model_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_hazard_unit #(.REG_W(RW), .BR_PENALTY(PEN)) u_pipe_hazard_unit (
        .clk(clk), .rst(rst),
        .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd), .id_branch(id_branch),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_load(ex_load),
        .mem_rs1(mem_rs1), .mem_rs2(mem_rs2), .mem_rd(mem_rd),
        .wb_rs1(wb_rs1), .wb_rs2(wb_rs2), .wb_rd(wb_rd),
        .stall(stall), .ex_bubble(ex_bubble), .fwd_a(fwd_a), .fwd_b(fwd_b),
        .hz_kind(hz_kind), .load_use(load_use)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit nz_eq(input logic [RW-1:0] a, input logic [RW-1:0] b);
        return (a != 0) && (a == b);
    endfunction

    function automatic int exp_fwd(input logic [RW-1:0] s);
        if (nz_eq(s, mem_rd)) return 1;
        if (nz_eq(s, wb_rd))  return 2;
        return 0;
    endfunction

    function automatic string fwd_tag(input logic [RW-1:0] s);
        if (nz_eq(s, mem_rd) && nz_eq(s, wb_rd)) return "R6";
        if (s == 0) return "R4";
        return "R5";
    endfunction

    function automatic int exp_kind();
        bit raw, waw, war;
        if (!id_valid) return 0;
        raw = nz_eq(id_rs1, ex_rd) || nz_eq(id_rs1, mem_rd) || nz_eq(id_rs1, wb_rd) ||
              nz_eq(id_rs2, ex_rd) || nz_eq(id_rs2, mem_rd) || nz_eq(id_rs2, wb_rd);
        waw = nz_eq(id_rd, ex_rd) || nz_eq(id_rd, mem_rd) || nz_eq(id_rd, wb_rd);
        war = nz_eq(id_rd, ex_rs1) || nz_eq(id_rd, ex_rs2) || nz_eq(id_rd, mem_rs1) ||
              nz_eq(id_rd, mem_rs2) || nz_eq(id_rd, wb_rs1) || nz_eq(id_rd, wb_rs2);
        if (raw) return 1;
        if (waw) return 2;
        if (war) return 4;
        return 0;
    endfunction

    function automatic string kind_tag(input int k);
        if (k == 1) return "R1";
        if (k == 2) return "R2";
        return "R3";
    endfunction

    function automatic int exp_lu();
        return (id_valid && ex_load && (nz_eq(id_rs1, ex_rd) || nz_eq(id_rs2, ex_rd))) ? 1 : 0;
    endfunction

    // Inputs are already set (at a negedge); check, then cross one edge.
    task automatic step(input string note);
        int  e_lu, e_st, e_k;
        bit  issue;
        #1;
        e_lu = exp_lu();
        e_st = (e_lu != 0 || model_cnt > 0) ? 1 : 0;
        e_k  = exp_kind();
        chk(e_lu ? "R7" : "R8", {note, " load_use"}, int'(load_use), e_lu);
        chk(model_cnt > 0 ? "R8" : "R7", {note, " stall"}, int'(stall), e_st);
        chk("R8", {note, " ex_bubble"}, int'(ex_bubble), e_st);
        chk(kind_tag(e_k), {note, " hz_kind"}, int'(hz_kind), e_k);
        chk(fwd_tag(ex_rs1), {note, " fwd_a"}, int'(fwd_a), exp_fwd(ex_rs1));
        chk(fwd_tag(ex_rs2), {note, " fwd_b"}, int'(fwd_b), exp_fwd(ex_rs2));
        issue = id_valid && id_branch && (e_st == 0);
        @(posedge clk);
        if (rst)             model_cnt = 0;
        else if (issue)      model_cnt = PEN;
        else if (model_cnt > 0) model_cnt--;
        @(negedge clk);
    endtask

    task automatic idle();
        id_valid = 0; id_branch = 0; ex_load = 0;
        id_rs1 = 0; id_rs2 = 0; id_rd = 0;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
        mem_rs1 = 0; mem_rs2 = 0; mem_rd = 0;
        wb_rs1 = 0; wb_rs2 = 0; wb_rd = 0;
    endtask

    function automatic logic [RW-1:0] rreg();
        return RW'($urandom_range(0, 3));
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_cnt = 0;

        // R10: quiet outputs after reset
        #1;
        chk("R10", "reset stall", int'(stall), 0);
        chk("R10", "reset kind", int'(hz_kind), 0);
        chk("R10", "reset fwd", int'({fwd_a, fwd_b}), 0);
        step("reset");

        // R1 with ALU producer in execute: flag, no stall (R7)
        idle(); id_valid = 1; id_rs1 = 3; ex_rd = 3;
        step("raw_alu");
        // R2
        idle(); id_valid = 1; id_rd = 4; mem_rd = 4;
        step("waw");
        // R3
        idle(); id_valid = 1; id_rd = 5; wb_rs2 = 5;
        step("war");
        // R3: invalid decode slot raises nothing
        idle(); id_valid = 0; id_rs1 = 7; ex_rd = 7; ex_load = 1;
        step("invalid");
        // R4: all zeros everywhere
        idle(); id_valid = 1;
        step("zero_regs");
        // R4: zero operand in execute next to zero destinations
        idle(); ex_rs1 = 0; mem_rd = 0; wb_rd = 0; ex_rs2 = 9; wb_rd = 9;
        step("zero_fwd");
        // R6: both forward sources match
        idle(); ex_rs1 = 6; ex_rs2 = 6; mem_rd = 6; wb_rd = 6;
        step("fwd_prio");
        // R5: writeback only
        idle(); ex_rs1 = 6; wb_rd = 6;
        step("fwd_wb");
        // R7: load-use on second source
        idle(); id_valid = 1; id_rs2 = 2; ex_rd = 2; ex_load = 1;
        step("load_use");

        // R9: branch held by load-use, then released; R8: two-cycle penalty
        idle(); id_valid = 1; id_branch = 1; id_rs1 = 8; ex_rd = 8; ex_load = 1;
        step("br_held");
        idle(); id_valid = 1; id_branch = 1;
        step("br_issue");
        idle(); id_valid = 1;
        step("br_pen1");
        step("br_pen2");
        step("br_done");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            id_valid  = ($urandom_range(0, 9) != 0);
            id_branch = ($urandom_range(0, 6) == 0);
            ex_load   = ($urandom_range(0, 2) == 0);
            id_rs1 = rreg(); id_rs2 = rreg(); id_rd = rreg();
            ex_rs1 = rreg(); ex_rs2 = rreg(); ex_rd = rreg();
            mem_rs1 = rreg(); mem_rs2 = rreg(); mem_rd = rreg();
            wb_rs1 = rreg(); wb_rs2 = rreg(); wb_rd = rreg();
            step("random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule